// File: doc/BRIEF.md
# Clock-Synchronous Serial Frame Receiver

This block takes a serial data line and its companion serial clock, both arriving from outside the system clock domain, and assembles 8-bit frames. Both lines are brought into the system clock domain through a flop chain. Each detected rising edge of the serial clock samples one data bit into a shift register, least significant bit first. When the eighth bit lands, the finished frame is offered to a holding register that the host reads.

The handoff is guarded by a data-full flag. A frame is accepted only while that flag is clear. A frame that completes while the flag is still set is dropped and raises an overrun flag instead. The overrun flag freezes the receiver and drives a lock output that a companion transmitter is expected to obey. The freeze lasts until the host clears the overrun flag. One interrupt enable gates two level interrupt requests, one per flag. The host clears each flag with its own strobe.

Top module: `sync_serial_rx`

## Requirements
- R1: The first serial bit of a frame lands in bit 0 of `rdata_o` and the eighth lands in bit 7.
- R2: Data is sampled on rising edges of the synchronized serial clock, and a frame completes on the eighth such edge. The bit count starts again at zero for the next frame.
- R3: A completed frame is copied to `rdata_o` and `full_o` becomes 1 only if `full_o` is 0 at that moment (a `clr_full_i` strobe in the same cycle counts as clearing it first).
- R4: A frame completing while `full_o` is 1 sets `ovr_o` to 1 and leaves `rdata_o` and `full_o` unchanged.
- R5: While `ovr_o` is 1, `lock_o` is 1 and serial clock edges are ignored. No frame is assembled or stored, and the first frame after release starts at bit 0.
- R6: A one-cycle high on `clr_full_i` returns `full_o` to 0. A one-cycle high on `clr_ovr_i` returns `ovr_o` and `lock_o` to 0.
- R7: Driving `rx_en_i` low clears the bit count and discards a partial frame, without changing `full_o`, `ovr_o` or `rdata_o`.
- R8: `irq_full_o` equals `full_o` AND `irq_en_i`, and `irq_err_o` equals `ovr_o` AND `irq_en_i`. Both are levels that fall as soon as the flag is cleared.
- R9: After synchronous reset, `rdata_o` is 0x00 and `full_o`, `ovr_o`, `lock_o`, `irq_full_o` and `irq_err_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_i | input | 1 | Serial clock, asynchronous to `clk` |
| sdata_i | input | 1 | Serial data, valid around the serial clock rising edge |
| rx_en_i | input | 1 | Receive enable; low holds the bit counter at zero |
| irq_en_i | input | 1 | Enable shared by both interrupt requests |
| clr_full_i | input | 1 | Strobe that clears the data-full flag |
| clr_ovr_i | input | 1 | Strobe that clears the overrun flag and releases the lock |
| rdata_o | output | 8 | Receive holding register |
| full_o | output | 1 | Data-full flag |
| ovr_o | output | 1 | Overrun error flag |
| lock_o | output | 1 | Receive and transmit lockout |
| irq_full_o | output | 1 | Data-full interrupt request, level |
| irq_err_o | output | 1 | Receive-error interrupt request, level |

## Verification
The embedded properties check, on every cycle, the rules that govern register updates:
- the holding register changes only in the cycle a handoff raises the data-full flag;
- an overrun leaves the holding register untouched;
- the bit counter stays at zero while locked or disabled;
- edge and frame-done pulses last one cycle.

Only the bench's scenarios can show the rest: that the bit order is least significant first, that a byte arrives intact across the synchronizer, that the counter realigns after a lockout or a disable in mid-frame, and that the interrupt levels follow the enable and the flag clears.

// File: rtl/sync_rx_pkg.sv
package sync_rx_pkg;

    localparam int RX_W  = 8;
    localparam int CNT_W = $clog2(RX_W);

    typedef logic [RX_W-1:0]  rx_word_t;
    typedef logic [CNT_W-1:0] rx_cnt_t;

    typedef struct packed {
        logic     valid;
        rx_word_t bits;
    } rx_frame_t;

    typedef enum logic [1:0] {
        UPD_NONE    = 2'd0,
        UPD_STORE   = 2'd1,
        UPD_OVERRUN = 2'd2
    } rx_upd_e;

    // Decide what a completed frame does, given the flag after any clear.
    function automatic rx_upd_e classify(input logic done, input logic full_eff);
        if (!done)
            return UPD_NONE;
        else if (full_eff)
            return UPD_OVERRUN;
        else
            return UPD_STORE;
    endfunction

endpackage

// File: rtl/sync_rx_sync.sv
module sync_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sclk_i,
    input  logic sdata_i,
    output logic rise_o,
    output logic data_o
);
    logic [STAGES-1:0] sc_q;
    logic [STAGES-1:0] sd_q;
    logic              prev_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) begin
                    sc_q <= '0;
                    sd_q <= '0;
                end else begin
                    sc_q <= sclk_i;
                    sd_q <= sdata_i;
                end
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) begin
                    sc_q <= '0;
                    sd_q <= '0;
                end else begin
                    sc_q <= {sc_q[STAGES-2:0], sclk_i};
                    sd_q <= {sd_q[STAGES-2:0], sdata_i};
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= sc_q[STAGES-1];
    end

    assign rise_o = sc_q[STAGES-1] & ~prev_q;
    assign data_o = sd_q[STAGES-1];

    // R2
    single_rise_chk: assert property (@(posedge clk) disable iff (rst)
        rise_o |=> !rise_o);

endmodule

// File: rtl/sync_rx_shifter.sv
module sync_rx_shifter
    import sync_rx_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      en_i,
    input  logic      lock_i,
    input  logic      rise_i,
    input  logic      data_i,
    output rx_frame_t frame_o
);
    rx_cnt_t   cnt_q;
    rx_word_t  sh_q;
    rx_word_t  sh_nxt;
    rx_frame_t frame_q;
    logic      last_bit;

    assign sh_nxt   = {data_i, sh_q[RX_W-1:1]};
    assign last_bit = (cnt_q == rx_cnt_t'(RX_W - 1));

    always_ff @(posedge clk) begin
        if (rst || !en_i || lock_i) begin
            cnt_q   <= '0;
            sh_q    <= '0;
            frame_q <= '0;
        end else begin
            frame_q.valid <= 1'b0;
            if (rise_i) begin
                sh_q <= sh_nxt;
                if (last_bit) begin
                    cnt_q         <= '0;
                    frame_q.valid <= 1'b1;
                    frame_q.bits  <= sh_nxt;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    assign frame_o = frame_q;

    // R5
    lock_hold_chk: assert property (@(posedge clk) disable iff (rst)
        lock_i |=> (cnt_q == '0) && !frame_q.valid);

    // R7
    disable_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> (cnt_q == '0));

    // R2
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        frame_q.valid |=> !frame_q.valid);

endmodule

// File: rtl/sync_rx_flags.sv
module sync_rx_flags
    import sync_rx_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  rx_frame_t frame_i,
    input  logic      clr_full_i,
    input  logic      clr_ovr_i,
    input  logic      irq_en_i,
    output rx_word_t  rdata_o,
    output logic      full_o,
    output logic      ovr_o,
    output logic      irq_full_o,
    output logic      irq_err_o
);
    rx_word_t rdr_q;
    logic     full_q;
    logic     ovr_q;
    logic     full_eff;
    rx_upd_e  upd;

    assign full_eff = full_q & ~clr_full_i;
    assign upd      = classify(frame_i.valid, full_eff);

    always_ff @(posedge clk) begin
        if (rst) begin
            rdr_q  <= '0;
            full_q <= 1'b0;
            ovr_q  <= 1'b0;
        end else begin
            if (clr_full_i) full_q <= 1'b0;
            if (clr_ovr_i)  ovr_q  <= 1'b0;
            case (upd)
                UPD_STORE: begin
                    rdr_q  <= frame_i.bits;
                    full_q <= 1'b1;
                end
                UPD_OVERRUN: ovr_q <= 1'b1;
                default: ;
            endcase
        end
    end

    assign rdata_o    = rdr_q;
    assign full_o     = full_q;
    assign ovr_o      = ovr_q;
    assign irq_full_o = full_q & irq_en_i;
    assign irq_err_o  = ovr_q & irq_en_i;

    // R3
    rdr_only_on_store_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(rdr_q) |-> $rose(full_q) || $past(full_q));

    // R3
    full_rise_from_frame_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(full_q) |-> $past(frame_i.valid));

    // R4
    overrun_keeps_data_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ovr_q) |-> $stable(rdr_q) && $past(full_q));

endmodule

// File: rtl/sync_serial_rx.sv
module sync_serial_rx
    import sync_rx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            sclk_i,
    input  logic            sdata_i,
    input  logic            rx_en_i,
    input  logic            irq_en_i,
    input  logic            clr_full_i,
    input  logic            clr_ovr_i,
    output logic [RX_W-1:0] rdata_o,
    output logic            full_o,
    output logic            ovr_o,
    output logic            lock_o,
    output logic            irq_full_o,
    output logic            irq_err_o
);
    logic      rise;
    logic      sbit;
    rx_frame_t frame;
    logic      ovr;

    sync_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .sclk_i  (sclk_i),
        .sdata_i (sdata_i),
        .rise_o  (rise),
        .data_o  (sbit)
    );

    sync_rx_shifter u_shift (
        .clk     (clk),
        .rst     (rst),
        .en_i    (rx_en_i),
        .lock_i  (ovr),
        .rise_i  (rise),
        .data_i  (sbit),
        .frame_o (frame)
    );

    sync_rx_flags u_flags (
        .clk        (clk),
        .rst        (rst),
        .frame_i    (frame),
        .clr_full_i (clr_full_i),
        .clr_ovr_i  (clr_ovr_i),
        .irq_en_i   (irq_en_i),
        .rdata_o    (rdata_o),
        .full_o     (full_o),
        .ovr_o      (ovr),
        .irq_full_o (irq_full_o),
        .irq_err_o  (irq_err_o)
    );

    assign ovr_o  = ovr;
    assign lock_o = ovr;

endmodule

// File: tb/tb_sync_serial_rx.sv
module tb_sync_serial_rx;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sclk_i = 1'b0, sdata_i = 1'b0;
    logic       rx_en_i = 1'b0, irq_en_i = 1'b0;
    logic       clr_full_i = 1'b0, clr_ovr_i = 1'b0;
    logic [7:0] rdata_o;
    logic       full_o, ovr_o, lock_o, irq_full_o, irq_err_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    sync_serial_rx dut (
        .clk(clk), .rst(rst), .sclk_i(sclk_i), .sdata_i(sdata_i),
        .rx_en_i(rx_en_i), .irq_en_i(irq_en_i),
        .clr_full_i(clr_full_i), .clr_ovr_i(clr_ovr_i),
        .rdata_o(rdata_o), .full_o(full_o), .ovr_o(ovr_o), .lock_o(lock_o),
        .irq_full_o(irq_full_o), .irq_err_o(irq_err_o)
    );

    // {clear full first, clear overrun first, byte sent, exp rdata, exp full, exp ovr}
    localparam logic [19:0] VEC [6] = '{
        {1'b1, 1'b0, 8'hA5, 8'hA5, 1'b1, 1'b0},
        {1'b1, 1'b0, 8'h3C, 8'h3C, 1'b1, 1'b0},
        {1'b0, 1'b0, 8'h81, 8'h3C, 1'b1, 1'b1},
        {1'b1, 1'b1, 8'h7E, 8'h7E, 1'b1, 1'b0},
        {1'b1, 1'b0, 8'h01, 8'h01, 1'b1, 1'b0},
        {1'b1, 1'b0, 8'h80, 8'h80, 1'b1, 1'b0}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic pulse_full();
        @(negedge clk) clr_full_i = 1'b1;
        @(negedge clk) clr_full_i = 1'b0;
    endtask

    task automatic pulse_ovr();
        @(negedge clk) clr_ovr_i = 1'b1;
        @(negedge clk) clr_ovr_i = 1'b0;
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) sdata_i = b[i];
            repeat (3) @(negedge clk);
            sclk_i = 1'b1;
            repeat (3) @(negedge clk);
            sclk_i = 1'b0;
        end
        repeat (8) @(negedge clk);
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9 reset state
        chk("R9 rdata", rdata_o, 8'h00);
        chk("R9 flags", {3'b0, full_o, ovr_o, lock_o, irq_full_o, irq_err_o}, 8'h00);

        rx_en_i  = 1'b1;
        irq_en_i = 1'b1;
        // R1 R2 R3 R4 R6 R8: vector walk
        foreach (VEC[k]) begin
            if (VEC[k][19]) pulse_full();
            if (VEC[k][18]) pulse_ovr();
            send_bits(VEC[k][17:10], 8);
            chk("R1 R3 R4 rdata", rdata_o, VEC[k][9:2]);
            chk("R3 full", {7'b0, full_o}, {7'b0, VEC[k][1]});
            chk("R4 ovr", {7'b0, ovr_o}, {7'b0, VEC[k][0]});
            chk("R8 irq_full", {7'b0, irq_full_o}, {7'b0, VEC[k][1]});
            chk("R8 irq_err", {7'b0, irq_err_o}, {7'b0, VEC[k][0]});
        end

        // R6 full clear
        pulse_full();
        chk("R6 full clear", {7'b0, full_o}, 8'h00);
        chk("R8 irq_full falls", {7'b0, irq_full_o}, 8'h00);

        // R5 lockout: build an overrun, then send while locked
        send_bits(8'h11, 8);
        send_bits(8'h22, 8);
        chk("R5 lock_o", {7'b0, lock_o}, 8'h01);
        send_bits(8'h55, 8);
        pulse_ovr();
        chk("R6 ovr clear", {6'b0, ovr_o, lock_o}, 8'h00);
        pulse_full();
        chk("R5 nothing stored while locked", {7'b0, full_o}, 8'h00);
        chk("R5 rdata kept", rdata_o, 8'h11);
        send_bits(8'hC3, 8);
        chk("R5 realigned frame", rdata_o, 8'hC3);

        // R7 disable mid-frame
        send_bits(8'hFF, 3);
        rx_en_i = 1'b0;
        repeat (4) @(negedge clk);
        chk("R7 full kept", {6'b0, full_o, ovr_o}, 8'h02);
        chk("R7 rdata kept", rdata_o, 8'hC3);
        rx_en_i = 1'b1;
        pulse_full();
        send_bits(8'h96, 8);
        chk("R7 partial discarded", rdata_o, 8'h96);

        // R8 enable gating
        pulse_full();
        irq_en_i = 1'b0;
        send_bits(8'h4B, 8);
        chk("R8 gated off", {6'b0, full_o, irq_full_o}, 8'h02);
        @(negedge clk) irq_en_i = 1'b1;
        #1;
        chk("R8 gated on", {7'b0, irq_full_o}, 8'h01);
        chk("R2 second byte order", rdata_o, 8'h4B);

        done = 1'b1;
        report();
    end

endmodule